// File: doc/BRIEF.md
# Delta-Panel Dot Decimator and Colour Serializer

This block sits between a video source that delivers one full RGB pixel (three 8-bit colours) per video clock and the data port of a delta-arranged TFT panel driver that takes one 8-bit colour dot at a time. From every run of seven source pixels it keeps three dots: one at group positions 0, 2 and 4. It drives those dots on a single 8-bit bus, together with a registered clock enable. The enable is high for three of every seven video clocks, so the panel's data clock runs at 3/7 of the video rate. Downstream, the enable gates the video clock in a glitch-free clock-gating cell.

The colour carried in each of the three slots of a group follows the delta colour-filter layout. It depends on the parity of the current line, on the vertical (up/down) and horizontal (left/right) scan controls, and on whether the panel takes 280 or 480 dots per line. Line timing comes from hsync and vsync. Each hsync restarts the seven-pixel group and the dot count. Each vsync makes the next line odd. When the line's dot quota has been sent, the block stays quiet until the next hsync.

The control is a four-state machine: BLANK (after reset or vsync, no line open), SYNC (hsync seen, counters held at zero), ACTIVE (dots being taken) and DONE (quota reached). Transitions:
- vsync from any state goes to BLANK.
- hsync from any state other than vsync goes to SYNC.
- SYNC, on the first cycle with hsync low, goes to ACTIVE. It goes to DONE instead if that first dot already meets the quota.
- ACTIVE goes to DONE when the last dot of the quota is taken.
- BLANK and DONE hold until a sync arrives.

Top module: `delta_dot_serializer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `dot_ce`, `dot_data` and `line_sync` are all zero.
- R2: Count the pixels from the first cycle with hsync low after an hsync, as pixel 0. A dot is taken from pixel k exactly when k mod 7 is 0, 2 or 4. `dot_ce` is high on the cycle after such a pixel and low on every other cycle, so it is never high on two cycles in a row.
- R3: While `dot_ce` is high, `dot_data` carries one colour of the pixel the dot was taken from. The colour is the one named by the slot: slot 0 at k mod 7 = 0, slot 1 at 2, slot 2 at 4. `dot_data` does not change while `dot_ce` is low.
- R4: With `wide_mode`=0 (280 dots), the slot order, written for slots 0,1,2 as odd line / even line, is:
  - ud=0, lr=1: GBR / BRG
  - ud=0, lr=0: GRB / BGR
  - ud=1, lr=1: BRG / GBR
  - ud=1, lr=0: BGR / GRB
- R5: With `wide_mode`=1 (480 dots), the slot order, written the same way, is:
  - ud=0, lr=1: GBR / RGB
  - ud=0, lr=0: RBG / BGR
  - ud=1, lr=1: RGB / GBR
  - ud=1, lr=0: BGR / RBG
- R6: After DOTS_NARROW dots (`wide_mode`=0) or DOTS_WIDE dots (`wide_mode`=1) on a line, `dot_ce` stays low until the next hsync, even part-way through a group.
- R7: The first hsync after a vsync opens an odd line. Each later hsync flips the line parity.
- R8: No dot is taken on a cycle with hsync or vsync high. No dot is taken after reset or vsync until an hsync has been seen.
- R9: `line_sync` equals hsync delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Video clock, one pixel per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync | input | 1 | Line sync, active high, restarts group and dot count |
| vsync | input | 1 | Frame sync, active high, makes the next line odd |
| pix_r | input | 8 | Red value of the current pixel |
| pix_g | input | 8 | Green value of the current pixel |
| pix_b | input | 8 | Blue value of the current pixel |
| wide_mode | input | 1 | 0: 280-dot panel, 1: 480-dot panel |
| scan_ud | input | 1 | Vertical scan direction control |
| scan_lr | input | 1 | 1: left-to-right scan, 0: right-to-left scan |
| dot_data | output | 8 | Serial colour dot |
| dot_ce | output | 1 | Registered enable for the gated data clock |
| line_sync | output | 1 | hsync delayed by one clock, aligned with the dot outputs |

## Verification
The assertions assume that hsync and vsync are synchronous to the video clock. They also assume that `wide_mode`, `scan_ud` and `scan_lr` stay still while a line is open. These controls are read on every dot, so a change mid-line would mix two orders within one line. The stimulus changes the mode and scan controls only during the vsync/blank interval that comes before each configuration. It sweeps all sixteen combinations of mode, vertical direction, horizontal direction and line parity. The dot quotas are shrunk to 10 and 14, so that each line ends part-way through a group and runs on well past its quota.

// File: rtl/dds_pkg.sv
package dds_pkg;

    typedef enum logic [1:0] {
        COL_R = 2'd0,
        COL_G = 2'd1,
        COL_B = 2'd2
    } colour_e;

    typedef enum logic [1:0] {
        ST_BLANK  = 2'd0,
        ST_SYNC   = 2'd1,
        ST_ACTIVE = 2'd2,
        ST_DONE   = 2'd3
    } line_state_e;

    typedef struct packed {
        colour_e s0;
        colour_e s1;
        colour_e s2;
    } order_t;

    function automatic order_t mk_order(input colour_e a, input colour_e b, input colour_e c);
        order_t o;
        o.s0 = a;
        o.s1 = b;
        o.s2 = c;
        return o;
    endfunction

endpackage

// File: rtl/dds_line_ctl.sv
module dds_line_ctl
    import dds_pkg::*;
#(
    parameter int GROUP_LEN   = 7,
    parameter int DOTS_NARROW = 280,
    parameter int DOTS_WIDE   = 480
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hsync,
    input  logic       vsync,
    input  logic       wide_mode,
    output logic       take,
    output logic [1:0] slot,
    output logic       line_odd
);

    localparam int MAX_DOTS = (DOTS_WIDE > DOTS_NARROW) ? DOTS_WIDE : DOTS_NARROW;
    localparam int CNT_W    = $clog2(MAX_DOTS + 1);
    localparam int PH_W     = $clog2(GROUP_LEN);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(GROUP_LEN - 1);
    localparam logic [PH_W-1:0] PH_S1   = PH_W'(2);
    localparam logic [PH_W-1:0] PH_S2   = PH_W'(4);

    line_state_e       state_q, state_d;
    logic [PH_W-1:0]   phase_q;
    logic [CNT_W-1:0]  dots_q;
    logic [CNT_W-1:0]  limit;
    logic              fresh_q;
    logic              running;
    logic              dot_pos;
    logic              last_dot;
    logic              hs_entry;

    assign limit    = wide_mode ? CNT_W'(DOTS_WIDE) : CNT_W'(DOTS_NARROW);
    assign running  = (state_q == ST_SYNC) || (state_q == ST_ACTIVE);
    assign dot_pos  = (phase_q == '0) || (phase_q == PH_S1) || (phase_q == PH_S2);
    assign take     = running && !hsync && !vsync && dot_pos;
    assign last_dot = (dots_q == limit - CNT_W'(1));
    assign hs_entry = hsync && !vsync && (state_q != ST_SYNC);

    always_comb begin
        slot = 2'd0;
        if (phase_q == PH_S1) slot = 2'd1;
        if (phase_q == PH_S2) slot = 2'd2;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (vsync) begin
            state_d = ST_BLANK;
        end else if (hsync) begin
            state_d = ST_SYNC;
        end else begin
            unique case (state_q)
                ST_BLANK:  state_d = ST_BLANK;
                ST_SYNC:   state_d = (take && last_dot) ? ST_DONE : ST_ACTIVE;
                ST_ACTIVE: state_d = (take && last_dot) ? ST_DONE : ST_ACTIVE;
                ST_DONE:   state_d = ST_DONE;
                default:   state_d = ST_BLANK;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_BLANK;
        else        state_q <= state_d;
    end

    // group phase and dot count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
            dots_q  <= '0;
        end else if (hsync || vsync) begin
            phase_q <= '0;
            dots_q  <= '0;
        end else if (running) begin
            phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + PH_W'(1);
            if (take) dots_q <= dots_q + CNT_W'(1);
        end
    end

    // line parity: first line after vsync is odd
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fresh_q  <= 1'b1;
            line_odd <= 1'b1;
        end else if (vsync) begin
            fresh_q  <= 1'b1;
        end else if (hs_entry) begin
            fresh_q  <= 1'b0;
            line_odd <= fresh_q ? 1'b1 : ~line_odd;
        end
    end

    a_r2_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q <= PH_LAST);
    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        dots_q <= CNT_W'(MAX_DOTS));
    a_r6_done_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |-> !take);
    a_r8_blank_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BLANK) |-> !take);
    a_r2_sync_holds_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SYNC) |-> (phase_q == '0 && dots_q == '0));
    a_r7_parity_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_entry && !fresh_q) |=> (line_odd != $past(line_odd)));

endmodule

// File: rtl/dds_order_lut.sv
module dds_order_lut
    import dds_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wide_mode,
    input  logic       scan_ud,
    input  logic       scan_lr,
    input  logic       line_odd,
    input  logic [1:0] slot,
    output colour_e    sel
);

    order_t ord;

    always_comb begin
        unique case ({wide_mode, scan_ud, scan_lr, line_odd})
            // narrow panel
            4'b0011: ord = mk_order(COL_G, COL_B, COL_R);
            4'b0010: ord = mk_order(COL_B, COL_R, COL_G);
            4'b0001: ord = mk_order(COL_G, COL_R, COL_B);
            4'b0000: ord = mk_order(COL_B, COL_G, COL_R);
            4'b0111: ord = mk_order(COL_B, COL_R, COL_G);
            4'b0110: ord = mk_order(COL_G, COL_B, COL_R);
            4'b0101: ord = mk_order(COL_B, COL_G, COL_R);
            4'b0100: ord = mk_order(COL_G, COL_R, COL_B);
            // wide panel
            4'b1011: ord = mk_order(COL_G, COL_B, COL_R);
            4'b1010: ord = mk_order(COL_R, COL_G, COL_B);
            4'b1001: ord = mk_order(COL_R, COL_B, COL_G);
            4'b1000: ord = mk_order(COL_B, COL_G, COL_R);
            4'b1111: ord = mk_order(COL_R, COL_G, COL_B);
            4'b1110: ord = mk_order(COL_G, COL_B, COL_R);
            4'b1101: ord = mk_order(COL_B, COL_G, COL_R);
            4'b1100: ord = mk_order(COL_R, COL_B, COL_G);
            default: ord = mk_order(COL_R, COL_G, COL_B);
        endcase
    end

    always_comb begin
        unique case (slot)
            2'd0:    sel = ord.s0;
            2'd1:    sel = ord.s1;
            default: sel = ord.s2;
        endcase
    end

    // R4 / R5: every order is a permutation of the three colours
    a_r4_order_perm: assert property (@(posedge clk) disable iff (!rst_n)
        (ord.s0 != ord.s1) && (ord.s1 != ord.s2) && (ord.s0 != ord.s2));
    a_r5_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (sel != colour_e'(2'd3)));

endmodule

// File: rtl/dds_dot_out.sv
module dds_dot_out
    import dds_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  colour_e       sel,
    input  logic          hsync,
    input  logic [DW-1:0] pix_r,
    input  logic [DW-1:0] pix_g,
    input  logic [DW-1:0] pix_b,
    output logic [DW-1:0] dot_data,
    output logic          dot_ce,
    output logic          line_sync
);

    logic [DW-1:0] chosen;

    always_comb begin
        unique case (sel)
            COL_R:   chosen = pix_r;
            COL_G:   chosen = pix_g;
            COL_B:   chosen = pix_b;
            default: chosen = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dot_data  <= '0;
            dot_ce    <= 1'b0;
            line_sync <= 1'b0;
        end else begin
            dot_ce    <= take;
            line_sync <= hsync;
            if (take) dot_data <= chosen;
        end
    end

    a_r3_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !dot_ce |-> $stable(dot_data));
    a_r2_ce_gap: assert property (@(posedge clk) disable iff (!rst_n)
        dot_ce |=> !dot_ce);
    a_r8_quiet_in_sync: assert property (@(posedge clk) disable iff (!rst_n)
        line_sync |-> !dot_ce);

endmodule

// File: rtl/delta_dot_serializer.sv
module delta_dot_serializer
    import dds_pkg::*;
#(
    parameter int DW          = 8,
    parameter int GROUP_LEN   = 7,
    parameter int DOTS_NARROW = 280,
    parameter int DOTS_WIDE   = 480
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hsync,
    input  logic          vsync,
    input  logic [DW-1:0] pix_r,
    input  logic [DW-1:0] pix_g,
    input  logic [DW-1:0] pix_b,
    input  logic          wide_mode,
    input  logic          scan_ud,
    input  logic          scan_lr,
    output logic [DW-1:0] dot_data,
    output logic          dot_ce,
    output logic          line_sync
);

    logic       take;
    logic [1:0] slot;
    logic       line_odd;
    colour_e    sel;

    dds_line_ctl #(
        .GROUP_LEN   (GROUP_LEN),
        .DOTS_NARROW (DOTS_NARROW),
        .DOTS_WIDE   (DOTS_WIDE)
    ) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .hsync     (hsync),
        .vsync     (vsync),
        .wide_mode (wide_mode),
        .take      (take),
        .slot      (slot),
        .line_odd  (line_odd)
    );

    dds_order_lut u_lut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wide_mode (wide_mode),
        .scan_ud   (scan_ud),
        .scan_lr   (scan_lr),
        .line_odd  (line_odd),
        .slot      (slot),
        .sel       (sel)
    );

    dds_dot_out #(.DW(DW)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .sel       (sel),
        .hsync     (hsync),
        .pix_r     (pix_r),
        .pix_g     (pix_g),
        .pix_b     (pix_b),
        .dot_data  (dot_data),
        .dot_ce    (dot_ce),
        .line_sync (line_sync)
    );

    a_r8_no_dot_on_vsync: assert property (@(posedge clk) disable iff (!rst_n)
        vsync |=> !dot_ce);
    a_r8_no_dot_on_hsync: assert property (@(posedge clk) disable iff (!rst_n)
        hsync |=> !dot_ce);

endmodule

// File: tb/sim_delta_dot_serializer.sv
module sim_delta_dot_serializer;

    localparam int NARROW = 10;
    localparam int WIDE   = 14;
    localparam int PIXELS = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hsync = 1'b0, vsync = 1'b0;
    logic [7:0] pix_r = '0, pix_g = '0, pix_b = '0;
    logic       wide_mode = 1'b0, scan_ud = 1'b0, scan_lr = 1'b0;
    logic [7:0] dot_data;
    logic       dot_ce, line_sync;

    int total = 0;
    int bad   = 0;
    logic prev_h = 1'b0;

    always #4 clk = ~clk;

    delta_dot_serializer #(.DOTS_NARROW(NARROW), .DOTS_WIDE(WIDE)) u0 (
        .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
        .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
        .wide_mode(wide_mode), .scan_ud(scan_ud), .scan_lr(scan_lr),
        .dot_data(dot_data), .dot_ce(dot_ce), .line_sync(line_sync)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // order strings from R4 and R5
    function automatic string order_of(input logic w, input logic ud, input logic lr, input logic odd);
        if (!w) begin
            if (!ud &&  lr) return odd ? "GBR" : "BRG";
            if (!ud && !lr) return odd ? "GRB" : "BGR";
            if ( ud &&  lr) return odd ? "BRG" : "GBR";
            return odd ? "BGR" : "GRB";
        end
        if (!ud &&  lr) return odd ? "GBR" : "RGB";
        if (!ud && !lr) return odd ? "RBG" : "BGR";
        if ( ud &&  lr) return odd ? "RGB" : "GBR";
        return odd ? "BGR" : "RBG";
    endfunction

    task automatic cyc(input logic h, input logic v, input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
        @(negedge clk);
        hsync = h; vsync = v; pix_r = r; pix_g = g; pix_b = b;
        @(posedge clk);
        #1;
        chk("R9 line_sync", int'(line_sync), int'(h));
        prev_h = h;
    endtask

    task automatic run_line(input int base, input logic odd);
        int dots = 0;
        int limit = wide_mode ? WIDE : NARROW;
        string ord = order_of(wide_mode, scan_ud, scan_lr, odd);
        cyc(1'b1, 1'b0, 8'hAA, 8'hBB, 8'hCC);
        chk("R8 hsync quiet", int'(dot_ce), 0);
        cyc(1'b1, 1'b0, 8'hAA, 8'hBB, 8'hCC);
        chk("R8 hsync quiet", int'(dot_ce), 0);
        for (int k = 0; k < PIXELS; k++) begin
            logic [7:0] r = 8'(base + 3*k + 1);
            logic [7:0] g = 8'(base + 3*k + 2);
            logic [7:0] b = 8'(base + 3*k + 3);
            int ph = k % 7;
            logic exp_ce = ((ph == 0) || (ph == 2) || (ph == 4)) && (dots < limit);
            cyc(1'b0, 1'b0, r, g, b);
            if (dots >= limit) chk("R6 quota stop", int'(dot_ce), 0);
            else               chk("R2 dot position", int'(dot_ce), int'(exp_ce));
            if (exp_ce) begin
                byte c = ord[ph/2];
                int e = (c == "R") ? int'(r) : (c == "G") ? int'(g) : int'(b);
                if (wide_mode) chk("R5 colour order", int'(dot_data), e);
                else           chk("R4 colour order", int'(dot_data), e);
                chk(odd ? "R7 odd line R3" : "R7 even line R3", int'(dot_data), e);
                dots++;
            end
        end
    endtask

    initial begin
        #(8 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) begin
            @(negedge clk);
            hsync = 1'b1;
            @(posedge clk); #1;
            chk("R1 reset ce", int'(dot_ce), 0);
            chk("R1 reset data", int'(dot_data), 0);
            chk("R1 reset sync", int'(line_sync), 0);
        end
        @(negedge clk);
        rst_n = 1'b1; hsync = 1'b0;
        @(posedge clk); #1;
        chk("R1 after reset ce", int'(dot_ce), 0);
        chk("R1 after reset data", int'(dot_data), 0);
        // no hsync yet: pixels must be ignored
        for (int i = 0; i < 10; i++) begin
            cyc(1'b0, 1'b0, 8'(i), 8'(i+1), 8'(i+2));
            chk("R8 before first hsync", int'(dot_ce), 0);
        end
        for (int cfg = 0; cfg < 8; cfg++) begin
            @(negedge clk);
            wide_mode = cfg[2]; scan_ud = cfg[1]; scan_lr = cfg[0];
            cyc(1'b0, 1'b1, 8'h11, 8'h22, 8'h33);
            chk("R8 vsync quiet", int'(dot_ce), 0);
            cyc(1'b0, 1'b1, 8'h11, 8'h22, 8'h33);
            chk("R8 vsync quiet", int'(dot_ce), 0);
            for (int i = 0; i < 4; i++) begin
                cyc(1'b0, 1'b0, 8'h44, 8'h55, 8'h66);
                chk("R8 blank after vsync", int'(dot_ce), 0);
            end
            run_line(cfg * 29, 1'b1);
            run_line(cfg * 29 + 7, 1'b0);
            run_line(cfg * 29 + 13, 1'b1);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule